// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is a single-master I2C controller that a host moves forward one bus event at a time. The host sees four byte-wide locations: a status/pointer location, a data location, a control location and an indirect window. It writes a request into the control location and then waits for the interrupt line. When the event has finished, the status location holds one 8-bit code that says exactly what happened on the wire. A STOP request is the one exception. It raises no interrupt, and the status simply falls back to the idle code.

The block drives the clock and data lines through open-drain enables: an enable at 1 pulls the line low. It reads the resolved line levels back. Every bit is split into four quarter periods, each `div+1` system clocks long. The divider is loaded through window entry 0. Window entry 1 takes a two-byte key that returns the controller to its reset state. While sending a 1, the block compares the line with its own drive and backs off when another master wins.

Control location bits: bit 5 requests a START, bit 4 requests a STOP, bit 3 is the event-complete flag and bit 2 enables acknowledge on reception. Location map: 0 reads status and writes the window pointer, 1 is data, 2 is control, 3 is the window data (it reads back the pointer).

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, irq is 0 and both line enables are 0.
- R2: A START request from idle waits for both lines high, then leaves status 0x08 with irq set. A START request while the bus is held gives 0x10.
- R3: In the address phase the block sends the data location (7-bit address in bits 7:1, bit 0 = 1 for read). The result is 0x18 or 0x20 for write with ACK or NACK, and 0x40 or 0x48 for read with ACK or NACK.
- R4: A data byte sent after 0x18 or 0x28 gives 0x28 when the slave acknowledges and 0x30 when it does not. The slave receives the byte MSB first.
- R5: A receive after 0x40 or 0x50 answers ACK when bit 2 is 1 (status 0x50) and NACK when bit 2 is 0 (status 0x58). The received byte is then readable at location 1.
- R6: A STOP request raises no irq. It produces a STOP condition on the wire, then status 0xF8 with both enables at 0.
- R7: irq is the event-complete flag. It stays set until the host writes control. A control write with bit 3 set starts nothing.
- R8: When a 1 being sent reads back as 0 during an address or data byte, the status is 0x38, irq is set and both lines are released. A later START request goes out once the bus is free.
- R9: Writing 0xA5 and then 0x5A to window entry 1 resets the controller (status 0xF8, irq 0, lines released). Any other sequence has no effect.
- R10: During a byte, SCL stays released for exactly 2*(div+1) clocks per bit, where div is the value written to window entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Host location select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the selected location |
| irq | output | 1 | Event-complete interrupt |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions watch four things on every cycle. The interrupt must hold until the host writes. A return to the idle code must never come with an interrupt. The clock must stay held low while a completed event waits on the host. Both lines must be free when the bus is idle or arbitration has been lost. Only the bench scenarios can show the exact code after each step. This covers the write path, a repeated START into a read with ACK then NACK, and both address NACKs. The scenarios also show the byte values that cross the wire, the SCL high time for a programmed divider, recovery after arbitration loss, and the two-byte reset key against a broken key.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter logic [7:0] DIV_INIT = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [7:0] C_IDLE = 8'hF8, C_START = 8'h08, C_RSTART = 8'h10,
                         C_AW_ACK = 8'h18, C_AW_NAK = 8'h20, C_DW_ACK = 8'h28,
                         C_DW_NAK = 8'h30, C_ARB = 8'h38, C_AR_ACK = 8'h40,
                         C_AR_NAK = 8'h48, C_DR_ACK = 8'h50, C_DR_NAK = 8'h58;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BYTE, S_STOP} st_t;

  st_t        state;
  logic       owned, si, sta, sto, aa, armed, rs, rx, is_addr, rw, samp, sda_hold;
  logic [7:0] status_q, data_q, ptr_q, div_q, qcnt, sh;
  logic [1:0] q;
  logic [3:0] bitn;
  logic       busy;

  wire ctrl_wr = wr_en && addr == 2'd2;
  wire win_wr  = wr_en && addr == 2'd3;
  wire srst    = win_wr && ptr_q == 8'd1 && armed && wdata == 8'h5A;
  wire launch  = ctrl_wr && !wdata[3] && state == S_IDLE;
  wire tick    = qcnt == div_q;
  wire bit_drv = bitn[3] ? (rx & aa) : (!rx & !sh[7]);
  wire ack     = !samp;

  assign busy = state != S_IDLE;
  assign irq  = si;

  always_comb begin
    case (addr)
      2'd0:    rdata = status_q;
      2'd1:    rdata = data_q;
      2'd2:    rdata = {2'b00, sta, sto, si, aa, 2'b00};
      default: rdata = ptr_q;
    endcase
  end

  always_comb begin
    case (state)
      S_WAIT:  begin scl_oe = 1'b0;                       sda_oe = 1'b0;            end
      S_START: begin scl_oe = (q == 2'd0) ? rs : (q == 2'd3); sda_oe = q[1];        end
      S_BYTE:  begin scl_oe = !q[1];                      sda_oe = bit_drv;         end
      S_STOP:  begin scl_oe = q == 2'd0;                  sda_oe = q != 2'd3;       end
      default: begin scl_oe = owned;                      sda_oe = owned & sda_hold; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; owned <= 1'b0; si <= 1'b0; sta <= 1'b0; sto <= 1'b0; aa <= 1'b0;
      armed <= 1'b0; rs <= 1'b0; rx <= 1'b0; is_addr <= 1'b0; rw <= 1'b0; samp <= 1'b1;
      sda_hold <= 1'b0; status_q <= C_IDLE; data_q <= '0; ptr_q <= '0; div_q <= DIV_INIT;
      qcnt <= '0; sh <= '0; q <= '0; bitn <= '0;
    end else if (srst) begin
      state <= S_IDLE; owned <= 1'b0; si <= 1'b0; sta <= 1'b0; sto <= 1'b0; aa <= 1'b0;
      armed <= 1'b0; status_q <= C_IDLE; qcnt <= '0; q <= '0;
    end else begin
      if (wr_en && addr == 2'd0) ptr_q <= wdata;
      if (wr_en && addr == 2'd1) data_q <= wdata;
      if (win_wr) begin
        armed <= ptr_q == 8'd1 && wdata == 8'hA5;
        if (ptr_q == 8'd0) div_q <= wdata;
      end
      if (ctrl_wr) begin
        sta <= wdata[5]; sto <= wdata[4]; aa <= wdata[2];
        if (!wdata[3]) si <= 1'b0;
      end
      qcnt <= (state == S_START || state == S_BYTE || state == S_STOP) && !tick ? qcnt + 8'd1 : 8'd0;

      case (state)
        S_IDLE: if (launch) begin
          q <= '0; bitn <= '0;
          if (wdata[4]) begin
            if (owned) state <= S_STOP;
            else begin status_q <= C_IDLE; sto <= 1'b0; end
          end else if (wdata[5]) begin
            if (owned) begin rs <= 1'b1; state <= S_START; end
            else state <= S_WAIT;
          end else if (owned && (status_q == C_START || status_q == C_RSTART)) begin
            state <= S_BYTE; rx <= 1'b0; is_addr <= 1'b1; rw <= data_q[0]; sh <= data_q;
          end else if (owned && (status_q == C_AW_ACK || status_q == C_DW_ACK)) begin
            state <= S_BYTE; rx <= 1'b0; is_addr <= 1'b0; sh <= data_q;
          end else if (owned && (status_q == C_AR_ACK || status_q == C_DR_ACK)) begin
            state <= S_BYTE; rx <= 1'b1; is_addr <= 1'b0;
          end
        end
        S_WAIT: if (scl_i && sda_i) begin state <= S_START; rs <= 1'b0; q <= '0; end
        S_START: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            state <= S_IDLE; owned <= 1'b1; sda_hold <= 1'b1; si <= 1'b1; sta <= 1'b0;
            status_q <= rs ? C_RSTART : C_START;
          end
        end
        S_BYTE: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd2) begin
            samp <= sda_i;
            if (!rx && !bitn[3] && sh[7] && !sda_i) begin
              state <= S_IDLE; owned <= 1'b0; si <= 1'b1; status_q <= C_ARB;
            end
          end
          if (q == 2'd3) begin
            if (!bitn[3]) begin
              sh <= {sh[6:0], samp}; bitn <= bitn + 4'd1;
            end else begin
              state <= S_IDLE; si <= 1'b1; sda_hold <= rx & aa;
              if (rx) begin
                data_q <= sh; status_q <= aa ? C_DR_ACK : C_DR_NAK;
              end else if (is_addr) begin
                status_q <= rw ? (ack ? C_AR_ACK : C_AR_NAK) : (ack ? C_AW_ACK : C_AW_NAK);
              end else begin
                status_q <= ack ? C_DW_ACK : C_DW_NAK;
              end
            end
          end
        end
        S_STOP: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            state <= S_IDLE; owned <= 1'b0; status_q <= C_IDLE; sto <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic [7:0] status
);
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_en |=> irq); // R7
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && status == 8'hF8 |-> !scl_oe && !sda_oe); // R1
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status) != 8'hF8 && status == 8'hF8 |-> !irq); // R6
  AST_HOLD_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq && status != 8'hF8 && status != 8'h38 |-> scl_oe); // R2
  AST_ARB_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq && status == 8'h38 |-> !scl_oe && !sda_oe); // R8
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .busy(busy), .status(status_q)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       irq, scl_oe, sda_oe;
  logic       slv_drv = 1'b0, arb_pull = 1'b0;
  wire        scl_line = !scl_oe;
  wire        sda_line = !(sda_oe || slv_drv || arb_pull);

  int checks = 0, errors = 0;
  bit done = 0;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: expected status per completed event
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       irq_d = 1'b0;
  logic [7:0] e_code;
  string      e_tag;
  always @(negedge clk) begin
    if (rst_n && irq && !irq_d) begin
      if (exp_q.size() == 0) chk(0, "R7", "unexpected irq", rdata, 0);
      else begin
        e_code = exp_q.pop_front(); e_tag = tag_q.pop_front();
        chk(rdata == e_code, e_tag, "status after event", rdata, e_code);
      end
    end
    irq_d = irq;
  end

  // SCL high-time measurement
  bit meas_en = 0;
  int run = 0, run_min = 9999, run_max = 0;
  always @(negedge clk) begin
    if (meas_en && scl_line) run++;
    else begin
      if (meas_en && run > 0) begin
        if (run < run_min) run_min = run;
        if (run > run_max) run_max = run;
      end
      run = 0;
    end
  end

  // behavioural slave at address 0x2C; NACKs data byte 0xEE; read data counts up from 0xA1
  localparam logic [6:0] SLV = 7'h2C;
  typedef enum {M_ADDR, M_WR, M_RD} smode_t;
  smode_t     mode = M_ADDR;
  logic       ps = 1'b1, pd = 1'b1, active = 1'b0, mack = 1'b0;
  logic [3:0] r = '0;
  logic [7:0] ssh = '0, txb = '0;
  logic [7:0] slv_rx[$];
  int         stops = 0;
  always @(negedge clk) begin
    ps <= scl_line; pd <= sda_line;
    if (ps && scl_line && pd && !sda_line) begin
      active <= 1'b1; mode <= M_ADDR; r <= '0; slv_drv <= 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      active <= 1'b0; slv_drv <= 1'b0; stops <= stops + 1;
    end else if (active) begin
      if (!ps && scl_line) begin
        if (r < 4'd8) ssh <= {ssh[6:0], sda_line};
        else if (mode == M_RD) mack <= !sda_line;
        r <= r + 4'd1;
      end else if (ps && !scl_line) begin
        if (r == 4'd8) begin
          case (mode)
            M_ADDR: slv_drv <= ssh[7:1] == SLV;
            M_WR: begin slv_drv <= ssh != 8'hEE; slv_rx.push_back(ssh); end
            default: slv_drv <= 1'b0;
          endcase
        end else if (r == 4'd9) begin
          r <= '0;
          if (mode == M_ADDR) begin
            if (ssh[7:1] == SLV && ssh[0]) begin mode <= M_RD; txb <= 8'hA1; slv_drv <= !1'b1; end
            else if (ssh[7:1] == SLV) begin mode <= M_WR; slv_drv <= 1'b0; end
            else begin active <= 1'b0; slv_drv <= 1'b0; end
          end else if (mode == M_RD) begin
            if (mack) begin txb <= txb + 8'd1; slv_drv <= !(txb[7] | (&txb[6:0])) ; end
            else begin slv_drv <= 1'b0; active <= 1'b0; end
          end else slv_drv <= 1'b0;
        end else if (mode == M_RD && r >= 4'd1 && r <= 4'd7) begin
          slv_drv <= !txb[7 - int'(r)];
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata; addr = 2'd0;
  endtask

  task automatic act(input logic [7:0] c, input logic [7:0] code, input string tag);
    int n;
    exp_q.push_back(code); tag_q.push_back(tag);
    wr(2'd2, c);
    n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(0, tag, "irq timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic stop_bus;
    int n, s0;
    logic [7:0] v;
    s0 = stops;
    wr(2'd2, 8'h10);
    n = 0; v = 8'h00;
    while (v != 8'hF8 && n < 20000) begin rd(2'd0, v); n++; end
    repeat (4) @(negedge clk);
    chk(v == 8'hF8 && !irq, "R6", "stop returns idle without irq", {irq, v}, 8'hF8);
    chk(!scl_oe && !sda_oe, "R6", "lines free after stop", {scl_oe, sda_oe}, 0);
    chk(stops == s0 + 1, "R6", "stop condition on wire", stops - s0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v);
    chk(v == 8'hF8 && !irq, "R1", "reset status", v, 8'hF8);
    chk(!scl_oe && !sda_oe, "R1", "reset lines", {scl_oe, sda_oe}, 0);

    wr(2'd0, 8'd0); wr(2'd3, 8'd3);

    // write path
    act(8'h20, 8'h08, "R2");
    wr(2'd1, {SLV, 1'b0});
    act(8'h00, 8'h18, "R3");
    wr(2'd2, 8'h08);
    repeat (200) @(negedge clk);
    rd(2'd0, v);
    chk(irq && v == 8'h18, "R7", "control write with flag set starts nothing", {irq, v}, 9'h118);
    wr(2'd1, 8'h3C);
    meas_en = 1;
    act(8'h00, 8'h28, "R4");
    meas_en = 0;
    chk(run_min == 8 && run_max == 8, "R10", "scl high time", run_max, 8);
    chk(slv_rx.size() > 0 && slv_rx[slv_rx.size()-1] == 8'h3C, "R4", "byte seen by slave",
        slv_rx.size() > 0 ? slv_rx[slv_rx.size()-1] : 0, 8'h3C);
    wr(2'd1, 8'hEE);
    act(8'h00, 8'h30, "R4");

    // repeated start into read
    act(8'h20, 8'h10, "R2");
    wr(2'd1, {SLV, 1'b1});
    act(8'h00, 8'h40, "R3");
    act(8'h04, 8'h50, "R5");
    rd(2'd1, v);
    chk(v == 8'hA1, "R5", "first read byte", v, 8'hA1);
    act(8'h00, 8'h58, "R5");
    rd(2'd1, v);
    chk(v == 8'hA2, "R5", "second read byte", v, 8'hA2);
    stop_bus();

    // address NACK paths
    act(8'h20, 8'h08, "R2");
    wr(2'd1, 8'h66);
    act(8'h00, 8'h20, "R3");
    stop_bus();
    act(8'h20, 8'h08, "R2");
    wr(2'd1, 8'h67);
    act(8'h00, 8'h48, "R3");
    stop_bus();

    // arbitration loss and recovery
    act(8'h20, 8'h08, "R2");
    wr(2'd1, 8'hFF);
    arb_pull = 1'b1;
    act(8'h00, 8'h38, "R8");
    chk(!scl_oe && !sda_oe, "R8", "lines released after loss", {scl_oe, sda_oe}, 0);
    repeat (4) @(negedge clk);
    arb_pull = 1'b0;
    act(8'h20, 8'h08, "R8");
    stop_bus();

    // soft reset key
    act(8'h20, 8'h08, "R2");
    wr(2'd0, 8'd1);
    wr(2'd3, 8'hA5); wr(2'd3, 8'h00); wr(2'd3, 8'h5A);
    rd(2'd0, v);
    chk(irq && v == 8'h08 && scl_oe, "R9", "broken key ignored", {irq, v}, 9'h108);
    wr(2'd3, 8'hA5); wr(2'd3, 8'h5A);
    rd(2'd0, v);
    chk(!irq && v == 8'hF8 && !scl_oe && !sda_oe, "R9", "key resets", {irq, v}, 8'hF8);
    repeat (20) @(negedge clk);
    act(8'h20, 8'h08, "R9");
    stop_bus();

    chk(exp_q.size() == 0, "R7", "all expected events seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule